// File: doc/BRIEF.md
# Carry-Select Group Adder

This block is a purely combinational adder of `WIDTH` bits. The operand bits are divided into `WIDTH/GROUP` equal slices. The lowest slice is a plain ripple adder that takes the external carry-in directly. Every slice above it holds two ripple adders that work in parallel. One of them assumes an incoming carry of zero and the other assumes an incoming carry of one. A two-way selector in each upper slice then picks the sum and the slice carry once the real carry from the slice below is known.

The selectors form a chain from the lowest slice to the highest. The critical path therefore runs through one slice of ripple delay plus one selector for each upper slice, rather than through every bit. The carry leaving the highest slice is the adder's carry-out.

Top module: `csa_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals `a + b + cin` evaluated on `WIDTH+1` bits.
- R2: The carry entering slice g (bit position g*GROUP) equals bit g*GROUP of the true sum of the lower g*GROUP bits of `a` and `b` plus `cin`. Slice g of `sum` equals the slice of `a` plus the slice of `b` plus that carry, modulo 2^GROUP.
- R3: Every slice above the lowest produces two results ahead of time. The carry-one result equals the carry-zero result plus one, modulo 2^GROUP. The carry-one slice carry is set whenever the carry-zero slice carry is set. The carry-one slice carry is set without the carry-zero one only when the carry-one result wraps to zero. At the ports, this means raising `cin` raises `{cout,sum}` by exactly one.
- R4: The lowest slice uses `cin` directly. With `a = b = 0`, `cin = 1` gives `sum = 1` and `cout = 0`.
- R5: A carry can cross every slice. With `a` all ones, `b = 0` and `cin = 1`, the result is `sum = 0` and `cout = 1`. When a carry stops partway up, only the slices below the stopping point are cleared.
- R6: `cout` is the carry out of the highest slice. With `a` all ones and `b = 1`, the result is `cout = 1` and `sum = 0`. With `a = b =` all ones and `cin = 1`, the result is `sum` all ones and `cout = 1`.
- R7: All-zero inputs give `sum = 0` and `cout = 0`.
- R8: The behaviour holds for any `GROUP` that divides `WIDTH`. A configuration that breaks this rule is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
The checker assumes the inputs have settled when it is evaluated. The block has no clock, so the checks treat every evaluation as a stable operand set. The checker also assumes the inputs carry only 0 and 1 values. The stimulus therefore changes the operands only at a clock edge and reads the outputs half a period later. It drives only two-state values, which come from counters and a shift-register sequence, so no unknown value reaches the internal adder copies.

// File: rtl/csa_pkg.sv
package csa_pkg;

  typedef struct packed {
    logic s;
    logic co;
  } fa_res_t;

  function automatic logic bit_sum(logic x, logic y, logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic bit_carry(logic x, logic y, logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  function automatic fa_res_t fa_eval(logic x, logic y, logic c);
    fa_res_t r;
    r.s  = bit_sum(x, y, c);
    r.co = bit_carry(x, y, c);
    return r;
  endfunction

endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell
  import csa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  fa_res_t res;
  assign res = fa_eval(x, y, ci);
  assign s   = res.s;
  assign co  = res.co;
endmodule

// File: rtl/csa_ripple_group.sv
module csa_ripple_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_fa_cell u_fa (
      .x (a[i]),
      .y (b[i]),
      .ci(chain[i]),
      .s (s[i]),
      .co(chain[i+1])
    );
  end

  assign co = chain[W];
endmodule

// File: rtl/csa_select_group.sv
module csa_select_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_ci,
  output logic [W-1:0] s,
  output logic         co,
  output logic [W-1:0] s_if0,
  output logic [W-1:0] s_if1,
  output logic         co_if0,
  output logic         co_if1
);
  csa_ripple_group #(.W(W)) u_zero (
    .a (a),
    .b (b),
    .ci(1'b0),
    .s (s_if0),
    .co(co_if0)
  );

  csa_ripple_group #(.W(W)) u_one (
    .a (a),
    .b (b),
    .ci(1'b1),
    .s (s_if1),
    .co(co_if1)
  );

  assign s  = sel_ci ? s_if1  : s_if0;
  assign co = sel_ci ? co_if1 : co_if0;
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NG = WIDTH / GROUP;

  if ((WIDTH % GROUP) != 0 || GROUP < 1) begin : g_bad_cfg
    $error("csa_adder: WIDTH must be a multiple of GROUP (R8)");
  end

  // Named internal events for the checker
  logic [NG:0]      grp_carry;
  logic [WIDTH-1:0] pre_sum0;
  logic [WIDTH-1:0] pre_sum1;
  logic [NG-1:0]    pre_co0;
  logic [NG-1:0]    pre_co1;

  assign grp_carry[0] = cin;

  for (genvar g = 0; g < NG; g++) begin : g_slice
    if (g == 0) begin : g_base
      logic [GROUP-1:0] s_lo;
      logic             c_lo;
      csa_ripple_group #(.W(GROUP)) u_base (
        .a (a[0 +: GROUP]),
        .b (b[0 +: GROUP]),
        .ci(grp_carry[0]),
        .s (s_lo),
        .co(c_lo)
      );
      assign sum[0 +: GROUP]      = s_lo;
      assign grp_carry[1]         = c_lo;
      assign pre_sum0[0 +: GROUP] = s_lo;
      assign pre_sum1[0 +: GROUP] = s_lo;
      assign pre_co0[0]           = c_lo;
      assign pre_co1[0]           = c_lo;
    end else begin : g_upper
      logic [GROUP-1:0] s_sel;
      logic             c_sel;
      csa_select_group #(.W(GROUP)) u_sel (
        .a     (a[g*GROUP +: GROUP]),
        .b     (b[g*GROUP +: GROUP]),
        .sel_ci(grp_carry[g]),
        .s     (s_sel),
        .co    (c_sel),
        .s_if0 (pre_sum0[g*GROUP +: GROUP]),
        .s_if1 (pre_sum1[g*GROUP +: GROUP]),
        .co_if0(pre_co0[g]),
        .co_if1(pre_co1[g])
      );
      assign sum[g*GROUP +: GROUP] = s_sel;
      assign grp_carry[g+1]        = c_sel;
    end
  end

  assign cout = grp_carry[NG];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input logic [WIDTH-1:0]       a,
  input logic [WIDTH-1:0]       b,
  input logic                   cin,
  input logic [WIDTH-1:0]       sum,
  input logic                   cout,
  input logic [WIDTH/GROUP:0]   grp_carry,
  input logic [WIDTH-1:0]       pre_sum0,
  input logic [WIDTH-1:0]       pre_sum1,
  input logic [WIDTH/GROUP-1:0] pre_co0,
  input logic [WIDTH/GROUP-1:0] pre_co1
);
  localparam int NG = WIDTH / GROUP;

  function automatic logic carry_at(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                    logic c, int k);
    logic [WIDTH:0] keep;
    logic [WIDTH:0] tot;
    keep = ~({(WIDTH+1){1'b1}} << k);
    tot  = ({1'b0, x} & keep) + ({1'b0, y} & keep) + {{WIDTH{1'b0}}, c};
    return tot[k];
  endfunction

  always_comb begin
    assert_sum_exact_R1: assert ({cout, sum} ==
      ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("R1: sum mismatch");
    for (int g = 0; g <= NG; g++) begin
      assert_group_carry_R2: assert (grp_carry[g] == carry_at(a, b, cin, g*GROUP))
        else $error("R2: carry into group %0d wrong", g);
    end
    for (int g = 1; g < NG; g++) begin
      assert_precompute_inc_R3: assert (pre_sum1[g*GROUP +: GROUP] ==
        pre_sum0[g*GROUP +: GROUP] + GROUP'(1))
        else $error("R3: precomputed pair not one apart in group %0d", g);
      assert_precompute_carry_R3: assert (!pre_co0[g] || pre_co1[g])
        else $error("R3: carry-one group carry missing in group %0d", g);
      assert_precompute_wrap_R3: assert (!(pre_co1[g] && !pre_co0[g]) ||
        (pre_sum1[g*GROUP +: GROUP] == '0))
        else $error("R3: extra carry without wrap in group %0d", g);
    end
  end
endmodule

bind csa_adder csa_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) chk_i (
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .grp_carry(grp_carry),
  .pre_sum0 (pre_sum0),
  .pre_sum1 (pre_sum1),
  .pre_co0  (pre_co0),
  .pre_co1  (pre_co1)
);

// File: tb/csa_adder_tb_top.sv
module csa_adder_tb_top;
  localparam int W  = 16;
  localparam int SW = 8;
  localparam int SG = 2;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [SW-1:0] sa, sb, ss;
  logic          sci, sco;

  csa_adder #(.WIDTH(W), .GROUP(4)) dut_i (
    .a(a), .b(b), .cin(ci), .sum(s), .cout(co)
  );

  csa_adder #(.WIDTH(SW), .GROUP(SG)) dut_small (
    .a(sa), .b(sb), .cin(sci), .sum(ss), .cout(sco)
  );

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive16(logic [W-1:0] x, logic [W-1:0] y, logic c);
    @(posedge clk);
    a <= x; b <= y; ci <= c;
    @(negedge clk);
  endtask

  function automatic logic [W:0] ref16(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + (W+1)'(c);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [W:0]  r0;
    a = '0; b = '0; ci = 1'b0;
    sa = '0; sb = '0; sci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R7: all-zero inputs
    @(negedge clk);
    check("R7", {co, s}, '0);

    // R4: lowest group takes cin directly
    drive16(16'h0000, 16'h0000, 1'b1);
    check("R4", {co, s}, 17'h00001);

    // R5: carry through every group, and partial runs
    drive16(16'hFFFF, 16'h0000, 1'b1);
    check("R5", {co, s}, 17'h10000);
    drive16(16'h0FFF, 16'h0000, 1'b1);
    check("R5", {co, s}, 17'h01000);
    drive16(16'h00FF, 16'h0000, 1'b1);
    check("R5", {co, s}, 17'h00100);
    drive16(16'h5FFF, 16'hA000, 1'b1);
    check("R5", {co, s}, 17'h10000);

    // R6: carry-out from the top group
    drive16(16'hFFFF, 16'h0001, 1'b0);
    check("R6", {co, s}, 17'h10000);
    drive16(16'hFFFF, 16'hFFFF, 1'b1);
    check("R6", {co, s}, 17'h1FFFF);
    drive16(16'h8000, 16'h8000, 1'b0);
    check("R6", {co, s}, 17'h10000);
    drive16(16'h7FFF, 16'h0000, 1'b1);
    check("R6", {co, s}, 17'h08000);

    // R1 and R3 on the default configuration: pseudo-random pairs,
    // each applied with cin low then high
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive16(lfsr[15:0], lfsr[31:16], 1'b0);
      check("R1", {co, s}, ref16(lfsr[15:0], lfsr[31:16], 1'b0));
      r0 = {co, s};
      drive16(lfsr[15:0], lfsr[31:16], 1'b1);
      check("R3", {co, s}, r0 + 17'd1);
    end

    // R8, R1, R2: exhaustive sweep of the 8-bit, 2-bit-group configuration
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          @(posedge clk);
          sa <= SW'(x); sb <= SW'(y); sci <= c[0];
          @(negedge clk);
          check("R8", {8'h00, sco, ss}, 17'(x + y + c));
          for (int g = 0; g < SW/SG; g++) begin
            int lowmask;
            int cin_g;
            int fld;
            lowmask = (1 << (g*SG)) - 1;
            cin_g = (((x & lowmask) + (y & lowmask) + c) >> (g*SG)) & 1;
            fld = (((x >> (g*SG)) & 3) + ((y >> (g*SG)) & 3) + cin_g) & 3;
            check("R2", 17'((ss >> (g*SG)) & 8'h03), 17'(fld));
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule